// File: doc/BRIEF.md
# Serial Port Control and Transmit-Empty Interrupt Front End

This block is the register and interrupt front end that sits between a processor bus and a serial transmitter/receiver pair. It holds the 8-bit control word: interrupt enables, transmitter and receiver enables, and the serial clock enable pair. It also holds a 2-bit clock-select field that picks the input tick for the bit-rate counter downstream. The shift registers and the bit-rate counter are outside this block. The control word is driven out on `ctrl_o` for the datapath to use.

The block keeps a transmit-empty flag. The transmit datapath sets it with a one-cycle `xfer_i` pulse when a byte moves from the data register into the shift register. Software can clear the flag only in two steps: it first reads the status register while the flag is set, and later writes a zero to the flag. The interrupt request `txe_irq_o` is the flag gated by the transmit-empty interrupt enable. Clearing that enable also withdraws the request.

A free-running prescaler produces `baud_en_o`, a one-cycle clock-enable pulse. The pulse comes every 1, 4, 16 or 64 system clocks, as the clock-select field chooses.

Top module: `serial_ctl_front`

## Requirements
- R1: The control register at address 1 is 8 bits, readable and writable at all times, and resets to 0x00. Bit 7 is the transmit-empty interrupt enable. Its value is driven on `ctrl_o`.
- R2: While `standby_i` is high, the control register is forced to 0x00 from the next clock edge on, and writes to it are ignored. The mode register is not affected.
- R3: The mode register at address 0 holds the clock select in bits 1:0 and resets to 00. Bits 7:2 read as 0, and writes to them have no effect.
- R4: `baud_en_o` is high for one cycle in every 1, 4, 16 or 64 cycles for clock select 00, 01, 10 or 11. Select 00 gives a pulse on every cycle.
- R5: The status register at address 2 shows the transmit-empty flag in bit 7, and its other bits read 0. The flag resets to 1.
- R6: A pulse on `xfer_i` sets the flag at the next edge. It also cancels any earlier read that had armed a clear.
- R7: A write to address 2 with bit 7 equal to 0 clears the flag only when it is armed. A read of address 2 (`re_i` high) that sees the flag at 1 arms it, and the arm lasts until the next set or clear. An unarmed write of 0 is ignored, and a write with bit 7 equal to 1 never sets the flag.
- R8: When `xfer_i` and an armed clearing write fall in the same cycle, the flag stays 1.
- R9: `txe_irq_o` is high exactly when the flag is 1 and control bit 7 is 1.
- R10: `rdata_o` follows `addr_i` combinationally, and address 3 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Standby request; clears the control register |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (arms the flag clear) |
| rdata_o | output | 8 | Read data for `addr_i` |
| xfer_i | input | 1 | Pulse: transmit data moved into the shift register |
| ctrl_o | output | 8 | Current control register |
| txe_irq_o | output | 1 | Transmit-empty interrupt request |
| baud_en_o | output | 1 | Prescaled clock enable for the bit-rate counter |

## Verification
A wrong flag or arm state shows up within one cycle of the triggering event. `txe_irq_o` changes, or fails to change, at the edge after `xfer_i` or after the clearing write. The next read of address 2 also shows the wrong bit 7. A lost or stale arm does not show when the read happens. It shows only at the write that follows, as a flag that clears when it should not, or stays set when it should clear. The bench therefore always checks by a read after every write. A wrong prescaler tap shows as a wrong pulse count over any 64-cycle window. A broken standby path shows on `ctrl_o` one edge after `standby_i` rises.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;
  localparam int DATA_W    = 8;
  localparam int SEL_W     = 2;
  localparam int MODE_ADDR = 0;
  localparam int CTRL_ADDR = 1;
  localparam int STAT_ADDR = 2;
  localparam int TIE_BIT   = 7;
  localparam int FLAG_BIT  = 7;

  typedef struct packed {
    logic tx_empty_ie;
    logic rx_ie;
    logic tx_en;
    logic rx_en;
    logic mp_ie;
    logic tx_end_ie;
    logic [1:0] sclk_en;
  } ctrl_t;
endpackage

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs
  import serial_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_mode_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [SEL_W-1:0]  sel_o
);
  ctrl_t            ctrl_q;
  logic [SEL_W-1:0] sel_q;

  // standby has priority over bus writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (standby_i) ctrl_q <= '0;
    else if (wr_ctrl_i) ctrl_q <= ctrl_t'(wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sel_q <= '0;
    else if (wr_mode_i) sel_q <= wdata_i[SEL_W-1:0];
  end

  assign ctrl_o = ctrl_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/serial_ctl_txe_flag.sv
module serial_ctl_txe_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, armed_q;
  logic clr_req;

  assign clr_req = wr_i && !wbit_i && armed_q;

  // set beats clear; any set or clear drops the arm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (set_i) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (clr_req) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (rd_i && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/serial_ctl_prescaler.sv
module serial_ctl_prescaler #(
  parameter int CNT_W    = 6,
  parameter int NUM_SEL  = 4,
  parameter int STEP_LOG = 2,
  localparam int SEL_W   = $clog2(NUM_SEL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_SEL-1:0] taps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // ratio 2^(g*STEP_LOG): tick when the low bits are all ones
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_tap
    localparam logic [CNT_W-1:0] MASK = CNT_W'((64'd1 << (g * STEP_LOG)) - 64'd1);
    assign taps[g] = ((cnt_q & MASK) == MASK);
  end

  assign tick_o = taps[sel_i];
endmodule

// File: rtl/serial_ctl_front.sv
module serial_ctl_front
  import serial_ctl_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int PRE_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              xfer_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              txe_irq_o,
  output logic              baud_en_o
);
  localparam int NUM_SEL = 1 << SEL_W;

  ctrl_t            ctrl;
  logic [SEL_W-1:0] sel;
  logic             hit_mode, hit_ctrl, hit_stat;
  logic             flag, armed;

  assign hit_mode = (addr_i == ADDR_W'(MODE_ADDR));
  assign hit_ctrl = (addr_i == ADDR_W'(CTRL_ADDR));
  assign hit_stat = (addr_i == ADDR_W'(STAT_ADDR));

  serial_ctl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .standby_i (standby_i),
    .wr_ctrl_i (we_i && hit_ctrl),
    .wr_mode_i (we_i && hit_mode),
    .wdata_i   (wdata_i),
    .ctrl_o    (ctrl),
    .sel_o     (sel)
  );

  serial_ctl_txe_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (xfer_i),
    .rd_i    (re_i && hit_stat),
    .wr_i    (we_i && hit_stat),
    .wbit_i  (wdata_i[FLAG_BIT]),
    .flag_o  (flag),
    .armed_o (armed)
  );

  serial_ctl_prescaler #(
    .CNT_W    (PRE_W),
    .NUM_SEL  (NUM_SEL),
    .STEP_LOG (2)
  ) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .tick_o (baud_en_o)
  );

  always_comb begin
    rdata_o = '0;
    if (hit_mode)      rdata_o[SEL_W-1:0] = sel;
    else if (hit_ctrl) rdata_o = ctrl;
    else if (hit_stat) rdata_o[FLAG_BIT] = flag;
  end

  assign ctrl_o    = ctrl;
  assign txe_irq_o = flag && ctrl.tx_empty_ie;
endmodule

// File: rtl/serial_ctl_front_chk.sv
module serial_ctl_front_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       standby_i,
  input logic       xfer_i,
  input logic       wr_stat,
  input logic       wbit,
  input logic [7:0] ctrl_o,
  input logic       txe_irq_o,
  input logic       baud_en_o,
  input logic       flag,
  input logic       armed,
  input logic [1:0] sel
);
  // R2
  assert_standby_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (ctrl_o == 8'h00));
  // R4
  assert_div1_every_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == 2'd0) |-> baud_en_o);
  // R6
  assert_set_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> flag);
  // R7
  assert_unarmed_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && !wbit && !armed && !xfer_i) |=> $stable(flag));
  assert_write_one_no_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wbit && !flag && !xfer_i) |=> !flag);
  assert_rise_needs_xfer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> $past(xfer_i));
  // R9
  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txe_irq_o |-> (ctrl_o[7] && flag));
  assert_irq_present_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[7] && flag) |-> txe_irq_o);
endmodule

bind serial_ctl_front serial_ctl_front_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .standby_i (standby_i),
  .xfer_i    (xfer_i),
  .wr_stat   (we_i && hit_stat),
  .wbit      (wdata_i[7]),
  .ctrl_o    (ctrl_o),
  .txe_irq_o (txe_irq_o),
  .baud_en_o (baud_en_o),
  .flag      (flag),
  .armed     (armed),
  .sel       (sel)
);

// File: tb/serial_ctl_front_bench.sv
`timescale 1ns/1ps
module serial_ctl_front_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0, re = 1'b0, xfer = 1'b0;
  logic [7:0] rdata, ctrl;
  logic       irq, baud_en;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  serial_ctl_front u_serial_ctl_front (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .re_i(re), .rdata_o(rdata), .xfer_i(xfer),
    .ctrl_o(ctrl), .txe_irq_o(irq), .baud_en_o(baud_en)
  );

  // {is_read, addr, wdata, expected}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'd1, 8'h00, 8'h00},  // R1 reset
    {1'b0, 2'd1, 8'hA5, 8'h00},
    {1'b1, 2'd1, 8'h00, 8'hA5},  // R1
    {1'b0, 2'd0, 8'h03, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h03},  // R3
    {1'b0, 2'd0, 8'hFE, 8'h00},
    {1'b1, 2'd0, 8'h00, 8'h02},  // R3 upper bits
    {1'b1, 2'd2, 8'h00, 8'h80},  // R5 reset flag, arms
    {1'b0, 2'd2, 8'h00, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'h00},  // R7 armed clear
    {1'b0, 2'd2, 8'h80, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'h00}   // R7 write 1 no set
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; re = 1'b1; #1;
    check(req, rdata, exp);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic pulse_xfer();
    @(negedge clk); xfer = 1'b1;
    @(negedge clk); xfer = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R5 reset status", {7'd0, irq}, 8'h00);
    check("R4 reset sel0 tick", {7'd0, baud_en}, 8'h01);
    rd("R10 unmapped addr 3", 2'd3, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) rd($sformatf("R1/R3/R5/R7 vec %0d", i), VEC[i][17:16], VEC[i][7:0]);
      else            wr(VEC[i][17:16], VEC[i][15:8]);
    end

    // R6 set; unarmed clear ignored
    pulse_xfer();
    wr(2'd2, 8'h00);
    rd("R7 unarmed write ignored", 2'd2, 8'h80);
    wr(2'd2, 8'h00);
    rd("R7 armed write clears", 2'd2, 8'h00);

    // R9 interrupt gating
    wr(2'd1, 8'h80);
    #1 check("R9 irq low flag 0", {7'd0, irq}, 8'h00);
    pulse_xfer(); #1;
    check("R6/R9 irq after xfer", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h00); #1;
    check("R9 irq off by enable", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h80); #1;
    check("R9 irq back on", {7'd0, irq}, 8'h01);
    rd("R5 flag set", 2'd2, 8'h80);
    wr(2'd2, 8'h00); #1;
    check("R9 irq removed by clear", {7'd0, irq}, 8'h00);

    // R8 set wins over armed clear
    pulse_xfer();
    rd("R8 pre-read", 2'd2, 8'h80);
    @(negedge clk); addr = 2'd2; wdata = 8'h00; we = 1'b1; xfer = 1'b1;
    @(negedge clk); we = 1'b0; xfer = 1'b0;
    rd("R8 set wins", 2'd2, 8'h80);

    // R2 standby
    wr(2'd0, 8'h01);
    wr(2'd1, 8'hFF);
    @(negedge clk); standby = 1'b1;
    @(negedge clk); #1;
    check("R2 ctrl cleared", ctrl, 8'h00);
    check("R2 irq off", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h3C);
    check("R2 write ignored in standby", ctrl, 8'h00);
    standby = 1'b0;
    rd("R2 mode kept", 2'd0, 8'h01);

    // R4 prescaler ratios
    for (int s = 0; s < 4; s++) begin
      int n;
      wr(2'd0, 8'(s));
      n = 0;
      for (int c = 0; c < 64; c++) begin
        @(negedge clk); #1;
        if (baud_en) n++;
      end
      check($sformatf("R4 pulses sel %0d", s), 8'(n), 8'(64 >> (2 * s)));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule